// File: doc/BRIEF.md
# Windowed Register File

This block holds the integer registers of a processor core whose procedure calls rotate a window over a large physical array instead of saving registers to memory. Software sees 32 registers named by 5-bit numbers. Register 0 is a constant zero. Registers 1 to 7 are shared by all procedures. Registers 8 to 31 are three groups of eight: outgoing parameters (8 to 15), locals (16 to 23) and incoming parameters (24 to 31). Each group is mapped through a current-window pointer. The physical array holds 8 + 16×NWIN words.

A save, issued on a procedure call, moves the pointer one window down. The callee's incoming group is then the same storage as the caller's outgoing group, so parameters and the stack pointer (register 14) pass across the call with no copying. In the callee, the caller's stack pointer is register 30, which serves as the frame pointer. A restore, issued on a return, moves the pointer back up.

The block counts the windows that are resident. A save that would need more windows than the array holds raises an overflow flag. A restore with no caller window resident raises an underflow flag. In both cases the pointer stays where it is, so that a trap handler outside the block can spill or fill a window. The block has two combinational read ports and one synchronous write port.

Top module: `win_regfile`

## Requirements
- R1: Reading register 0 gives zero on either port at all times, and a write to register 0 changes nothing.
- R2: Registers 1 to 7 map to the same storage in every window. A value written there reads back unchanged after any number of saves and restores.
- R3: Registers 8 to 23 are private to the current window. After a save, a local written in the caller reads as that window's own contents, not the caller's. After the matching restore, the caller's values are seen again.
- R4: An accepted save (save_i=1, restore_i=0, no overflow) sets cwp_o to the previous value minus one, modulo NWIN, at the next clock edge, and raises the resident count by one.
- R5: After an accepted save, registers 24 to 31 read the values the caller wrote to registers 8 to 15. In particular, the caller's register 14 (stack pointer) reads as register 30 (frame pointer).
- R6: An accepted restore (restore_i=1, save_i=0, no underflow) sets cwp_o to the previous value plus one, modulo NWIN, and undoes exactly one save.
- R7: ovf_o is 1 in the same cycle exactly when save_i=1, restore_i=0 and NWIN−1 windows are resident. The pointer and the count then stay unchanged.
- R8: unf_o is 1 in the same cycle exactly when restore_i=1, save_i=0 and only one window is resident. The pointer and the count then stay unchanged.
- R9: When save_i and restore_i are both 1, the pointer and the count do not change and neither flag is raised.
- R10: A write issued in the same cycle as a save or restore goes to the window that was current before the pointer moves.
- R11: Reads are combinational. When the write port and a read port name the same register in the same cycle, the read port returns the write data.
- R12: While rst_ni is low, cwp_o is 0, one window is resident, and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_addr_i | input | 5 | Read port A register number |
| rd_a_data_o | output | DW | Read port A data |
| rd_b_addr_i | input | 5 | Read port B register number |
| rd_b_data_o | output | DW | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write register number |
| wr_data_i | input | DW | Write data |
| save_i | input | 1 | Move the window for a call |
| restore_i | input | 1 | Move the window for a return |
| cwp_o | output | $clog2(NWIN) | Current-window pointer |
| ovf_o | output | 1 | Save refused: window spill needed |
| unf_o | output | 1 | Restore refused: window fill needed |

## Verification
The bench builds the block with NWIN=4 and DW=32. With these values only three windows can be resident. Random runs of saves and restores therefore reach both the overflow and the underflow limits many times, and the very first save wraps the pointer from 0 to 3. This exercises the modulo arithmetic and the overlap across the array's end, where the incoming group of the top window maps onto window 0's outgoing group. The expected read data come from a bench model that stores outgoing and local groups per window and aliases each incoming group onto the next window's outgoing group.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int ARCH_W = 5;
  localparam int GRP_SZ = 8;
  localparam int WIN_SZ = 2 * GRP_SZ;

  typedef enum logic [1:0] {
    GRP_GLOB = 2'd0,
    GRP_OUT  = 2'd1,
    GRP_LOC  = 2'd2,
    GRP_IN   = 2'd3
  } grp_e;
endpackage

// File: rtl/wrf_map.sv
module wrf_map
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN),
  parameter int PW   = $clog2(GRP_SZ + WIN_SZ * NWIN)
) (
  input  logic [ARCH_W-1:0] arch_i,
  input  logic [CW-1:0]     cwp_i,
  output logic [PW-1:0]     phys_o
);
  logic [CW-1:0] nxt;
  int            idx;
  int            off;

  // window w: outs at base(w), locals at base(w)+8, ins alias outs of w+1
  always_comb begin
    nxt = (cwp_i == CW'(NWIN - 1)) ? '0 : cwp_i + CW'(1);
    off = int'(arch_i[2:0]);
    unique case (grp_e'(arch_i[4:3]))
      GRP_GLOB: idx = off;
      GRP_OUT:  idx = GRP_SZ + WIN_SZ * int'(cwp_i) + off;
      GRP_LOC:  idx = GRP_SZ + WIN_SZ * int'(cwp_i) + GRP_SZ + off;
      default:  idx = GRP_SZ + WIN_SZ * int'(nxt) + off;
    endcase
    phys_o = PW'(idx);
  end
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl #(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN),
  parameter int NW   = $clog2(NWIN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          save_i,
  input  logic          restore_i,
  output logic [CW-1:0] cwp_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [CW-1:0] cwp_q;
  logic [NW-1:0] cnt_q;
  logic          full, last, do_save, do_rest;

  assign full    = (cnt_q == NW'(NWIN - 1));
  assign last    = (cnt_q == NW'(1));
  assign ovf_o   = save_i & ~restore_i & full;
  assign unf_o   = restore_i & ~save_i & last;
  assign do_save = save_i & ~restore_i & ~full;
  assign do_rest = restore_i & ~save_i & ~last;
  assign cwp_o   = cwp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      cnt_q <= NW'(1);
    end else if (do_save) begin
      cwp_q <= (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - CW'(1);
      cnt_q <= cnt_q + NW'(1);
    end else if (do_rest) begin
      cwp_q <= (cwp_q == CW'(NWIN - 1)) ? '0 : cwp_q + CW'(1);
      cnt_q <= cnt_q - NW'(1);
    end
  end

  // R4
  save_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !restore_i && !ovf_o) |=>
      (cwp_o == (($past(cwp_o) == '0) ? CW'(NWIN - 1) : $past(cwp_o) - CW'(1))));
  // R6
  rest_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !unf_o) |=>
      (cwp_o == (($past(cwp_o) == CW'(NWIN - 1)) ? '0 : $past(cwp_o) + CW'(1))));
  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> $stable(cwp_o));
  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> $stable(cwp_o));
  // R9
  both_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && restore_i) |=> $stable(cwp_o));
  // R7
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_o, unf_o}));
  // R4
  count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= NW'(1)) && (cnt_q <= NW'(NWIN - 1)));
endmodule

// File: rtl/wrf_array.sv
module wrf_array #(
  parameter int DW    = 32,
  parameter int DEPTH = 136,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [PW-1:0] rd_idx_i [2],
  output logic [DW-1:0] rd_data_o [2]
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (wr_en_i && (wr_idx_i == rd_idx_i[p])) rd_data_o[p] = wr_data_i;
      else                                      rd_data_o[p] = mem_q[rd_idx_i[p]];
    end
  end

  // R1
  no_zero_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_idx_i != '0));
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int CW    = $clog2(NWIN),
  localparam int DEPTH = GRP_SZ + WIN_SZ * NWIN,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [4:0]    rd_a_addr_i,
  output logic [DW-1:0] rd_a_data_o,
  input  logic [4:0]    rd_b_addr_i,
  output logic [DW-1:0] rd_b_data_o,
  input  logic          wr_en_i,
  input  logic [4:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          save_i,
  input  logic          restore_i,
  output logic [CW-1:0] cwp_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [CW-1:0] cwp;
  logic [4:0]    arch [3];
  logic [PW-1:0] phys [3];
  logic [PW-1:0] rd_idx [2];
  logic [DW-1:0] rd_data [2];
  logic          we;

  assign arch[0] = rd_a_addr_i;
  assign arch[1] = rd_b_addr_i;
  assign arch[2] = wr_addr_i;
  assign we      = wr_en_i & (wr_addr_i != '0);

  wrf_ctrl #(.NWIN(NWIN), .CW(CW)) ctrl_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .save_i   (save_i),
    .restore_i(restore_i),
    .cwp_o    (cwp),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
  );

  for (genvar k = 0; k < 3; k++) begin : g_map
    wrf_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) map_i (
      .arch_i(arch[k]),
      .cwp_i (cwp),
      .phys_o(phys[k])
    );
  end

  assign rd_idx[0] = phys[0];
  assign rd_idx[1] = phys[1];

  wrf_array #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) array_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (we),
    .wr_idx_i (phys[2]),
    .wr_data_i(wr_data_i),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_data)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
  assign cwp_o       = cwp;

  // R1
  r0_read_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == 5'd0) |-> (rd_a_data_o == '0));
  // R1
  r0_read_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_addr_i == 5'd0) |-> (rd_b_data_o == '0));
  // R11
  fwd_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && (wr_addr_i == rd_a_addr_i)) |-> (rd_a_data_o == wr_data_i));
endmodule

// File: tb/win_regfile_tb_top.sv
module win_regfile_tb_top;
  localparam int P    = 10;
  localparam int NWIN = 4;
  localparam int DW   = 32;
  localparam int CW   = $clog2(NWIN);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    ra = '0, rb = '0, wa = '0;
  logic [DW-1:0] da, db, wd = '0;
  logic          we = 1'b0, sv = 1'b0, rs = 1'b0;
  logic [CW-1:0] cwp;
  logic          ovf, unf;

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] m_glob [8];
  logic [DW-1:0] m_out  [NWIN][8];
  logic [DW-1:0] m_loc  [NWIN][8];
  int            m_cwp, m_cnt;

  always #(P/2) clk = ~clk;

  win_regfile #(.NWIN(NWIN), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_addr_i(ra), .rd_a_data_o(da),
    .rd_b_addr_i(rb), .rd_b_data_o(db),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .save_i(sv), .restore_i(rs),
    .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf)
  );

  function automatic logic [DW-1:0] m_read(int w, logic [4:0] a);
    if (a == 0)       return '0;
    else if (a < 8)   return m_glob[a];
    else if (a < 16)  return m_out[w][a-8];
    else if (a < 24)  return m_loc[w][a-16];
    else              return m_out[(w+1)%NWIN][a-24];
  endfunction

  function automatic logic [DW-1:0] m_port(logic [4:0] a);
    if (we && wa != 0 && wa == a) return wd;
    return m_read(m_cwp, a);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 8; i++) m_glob[i] = '0;
    for (int w = 0; w < NWIN; w++)
      for (int i = 0; i < 8; i++) begin
        m_out[w][i] = '0;
        m_loc[w][i] = '0;
      end
    m_cwp = 0;
    m_cnt = 1;
  endtask

  task automatic m_write(int w, logic [4:0] a, logic [DW-1:0] d);
    if (a == 0) return;
    else if (a < 8)  m_glob[a] = d;
    else if (a < 16) m_out[w][a-8] = d;
    else if (a < 24) m_loc[w][a-16] = d;
    else             m_out[(w+1)%NWIN][a-24] = d;
  endtask

  // one cycle: drive at negedge, compare combinational outputs, commit at posedge
  task automatic step(string req, logic [4:0] a, logic [4:0] b, logic w_en,
                      logic [4:0] w_a, logic [DW-1:0] w_d, logic s, logic r);
    logic e_ovf, e_unf;
    @(negedge clk);
    ra = a; rb = b; we = w_en; wa = w_a; wd = w_d; sv = s; rs = r;
    #(P/4);
    e_ovf = s && !r && (m_cnt == NWIN-1);
    e_unf = r && !s && (m_cnt == 1);
    check(req, da, m_port(a));
    check(req, db, m_port(b));
    check("R4", DW'(cwp), DW'(m_cwp));
    check("R7", DW'(ovf), DW'(e_ovf));
    check("R8", DW'(unf), DW'(e_unf));
    @(posedge clk);
    if (w_en) m_write(m_cwp, w_a, w_d);
    if (s && !r && !e_ovf) begin m_cwp = (m_cwp + NWIN - 1) % NWIN; m_cnt++; end
    if (r && !s && !e_unf) begin m_cwp = (m_cwp + 1) % NWIN; m_cnt--; end
    #1;
  endtask

  initial begin
    #(P*200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    m_reset();
    // R12: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ra = 5'(i * 7 + 3); rb = 5'(31 - i * 5);
      #(P/4);
      check("R12", da, '0);
      check("R12", db, '0);
      check("R12", DW'(cwp), '0);
    end
    @(negedge clk); rst_n = 1'b1;

    step("R12", 5'd24, 5'd8, 1'b0, 5'd0, '0, 1'b0, 1'b0);
    step("R2",  5'd3,  5'd0, 1'b1, 5'd3,  32'h6106_0003, 1'b0, 1'b0);
    step("R5",  5'd8,  5'd9, 1'b1, 5'd8,  32'hA000_0008, 1'b0, 1'b0);
    step("R5",  5'd14, 5'd0, 1'b1, 5'd14, 32'h5000_0014, 1'b0, 1'b0);
    step("R3",  5'd16, 5'd0, 1'b1, 5'd16, 32'h1000_0000, 1'b0, 1'b0);
    // R10: write lands in caller window while save moves pointer
    step("R10", 5'd9,  5'd0, 1'b1, 5'd9,  32'hB000_0009, 1'b1, 1'b0);
    step("R5",  5'd24, 5'd30, 1'b0, 5'd0, '0, 1'b0, 1'b0);
    step("R10", 5'd25, 5'd3,  1'b0, 5'd0, '0, 1'b0, 1'b0);
    step("R3",  5'd16, 5'd8,  1'b1, 5'd16, 32'h1000_0001, 1'b1, 1'b0);
    step("R7",  5'd16, 5'd24, 1'b0, 5'd0, '0, 1'b1, 1'b0);
    step("R9",  5'd16, 5'd3,  1'b0, 5'd0, '0, 1'b1, 1'b1);
    step("R6",  5'd16, 5'd0,  1'b0, 5'd0, '0, 1'b0, 1'b1);
    step("R6",  5'd16, 5'd25, 1'b0, 5'd0, '0, 1'b0, 1'b1);
    step("R3",  5'd16, 5'd8,  1'b0, 5'd0, '0, 1'b0, 1'b0);
    step("R8",  5'd14, 5'd9,  1'b0, 5'd0, '0, 1'b0, 1'b1);
    step("R1",  5'd0,  5'd0,  1'b1, 5'd0, 32'hDEAD_BEEF, 1'b0, 1'b0);
    step("R1",  5'd0,  5'd3,  1'b0, 5'd0, '0, 1'b0, 1'b0);
    step("R11", 5'd20, 5'd20, 1'b1, 5'd20, 32'hF00D_0020, 1'b0, 1'b0);
    step("R11", 5'd27, 5'd11, 1'b1, 5'd27, 32'hF00D_0027, 1'b0, 1'b0);
    step("R5",  5'd11, 5'd27, 1'b0, 5'd0, '0, 1'b0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      step("R3", 5'($urandom), 5'($urandom), r[0], 5'($urandom), $urandom,
           (r[7:4] < 4'd3), (r[11:8] < 4'd3));
    end

    @(negedge clk); we = 1'b0; sv = 1'b0; rs = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule